// File: doc/BRIEF.md
# Paging Address Translator with Translation Buffer

This block turns a processor's logical address into a physical address with single-level paging. The upper bits of the address select a page. The lower bits are an offset inside that page, and they pass through unchanged. A small fully associative translation buffer holds recent page-to-frame mappings. When the buffer holds the page, the result is returned with no memory traffic. When it does not, the block reads the page-table entry from memory, stores a valid entry in the buffer and completes the request. Two registers locate the page table: a base address and an entry count. Software loads them through a plain configuration write port.

Requests and responses use valid/ready. A request is taken in a cycle where `req_valid` and `req_ready` are both high. Only one translation is in flight at a time. `req_ready` stays low while a table walk is running, and also while an earlier response is still waiting to be taken. A response stays on the bus, unchanged, until `rsp_ready` is seen high. The table-entry read uses its own handshake. The address is held until `mem_req_ready` is seen. The block accepts `mem_rsp_valid` in any cycle of the wait state, so the memory side needs no ready signal. A `flush` pulse or a write to the base register drops every buffered mapping. Two saturating counters count buffer hits and misses.

Top module: `xlat_paging_mmu`

## Requirements
- R1: On a buffer hit, `rsp_paddr` equals the stored frame number followed by the unchanged low PAGE_BITS offset bits, with `rsp_fault`=0. It is valid in the cycle after acceptance, and no memory read is issued.
- R2: On a miss of an in-range page, `mem_req_valid` rises in the cycle after acceptance. `mem_req_addr` is base + page*4, and the address stays stable until `mem_req_ready` is seen.
- R3: A fetched entry whose bit PTE_W-1 is 1 is valid, and its low FRAME_W bits are the frame. The entry is stored in the buffer. The response {frame, offset} with no fault appears two cycles after the `mem_rsp_valid` cycle, and a later access to the same page hits.
- R4: A page number greater than or equal to the length register gives a fault response in the cycle after acceptance, with no memory read. Both table registers reset to 0, so every access faults until they are loaded.
- R5: A fetched entry with bit PTE_W-1 equal to 0 gives a fault response in the cycle after `mem_rsp_valid`. The buffer is not filled, so the next access to that page misses again.
- R6: A `flush` pulse, or a configuration write with `cfg_sel`=0 (base register), empties the buffer. The next access to any page misses. `cfg_sel`=1 writes the length register and does not flush.
- R7: A new entry goes into the lowest-numbered empty slot. When no slot is empty, it goes into the slot named by a round-robin pointer. The pointer starts at 0, moves up by one (wrapping) each time it picks a victim, and is not reset by a flush.
- R8: After reset `req_ready`=1, `rsp_valid`=0 and `mem_req_valid`=0. `req_ready` is low from the acceptance of a miss until its response has been issued, and low while a response is held back by `rsp_ready`=0.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the response holds its valid, address and fault values.
- R10: `hit_count` and `miss_count` reset to 0. Each rises by one in the cycle after a request for an in-range page is accepted as a hit or a miss, and each stops at 0xFFFF. Length faults count as neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Empty the translation buffer |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the table base, 1 the table length |
| cfg_wdata | input | MEM_AW | Configuration write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request can be accepted |
| req_laddr | input | LADDR_W | Logical address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | FRAME_W+PAGE_BITS | Physical address (0 on fault) |
| rsp_fault | output | 1 | Translation faulted |
| mem_req_valid | output | 1 | Table-entry read request |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | MEM_AW | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | PTE_W | Table entry |
| hit_count | output | CNT_W | Saturating hit counter |
| miss_count | output | CNT_W | Saturating miss counter |

## Verification
Each result has a fixed number of clock edges after its cause. A hit or a length fault responds one edge after acceptance, and the counters move on that same edge. A miss raises the memory request one edge after acceptance. An invalid entry faults one edge after the data returns, and a valid entry responds two edges after it. The bench drives inputs on the falling edge and samples outputs on the next falling edge, after exactly the number of rising edges that each path needs. A behavioural model of the buffer, its slots and its round-robin pointer predicts every result, and the model's counters are compared with the outputs on every clock.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_FETCH = 2'd1,
    S_WAIT  = 2'd2,
    S_FILL  = 2'd3
  } walk_state_e;

  typedef enum logic {
    CFG_BASE = 1'b0,
    CFG_LEN  = 1'b1
  } cfg_sel_e;

  localparam int unsigned PTE_SHIFT     = 2;
  localparam int unsigned MIN_PAGE_BITS = 9;
  localparam int unsigned MAX_PAGE_BITS = 13;

endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0] fill_frame
);

  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]   ent_valid;
  logic [VPN_W-1:0]   ent_vpn   [DEPTH];
  logic [FRAME_W-1:0] ent_frame [DEPTH];
  logic [DEPTH-1:0]   match;
  logic [IDX_W-1:0]   rr_ptr;
  logic [IDX_W-1:0]   free_idx;
  logic               free_found;
  logic [IDX_W-1:0]   victim;

  // parallel compare against every slot
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && (ent_vpn[g] == lk_vpn);
  end

  always_comb begin
    lk_frame = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) lk_frame = lk_frame | ent_frame[i];
    end
    lk_hit = |match;
  end

  // lowest empty slot wins
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign victim = free_found ? free_idx : rr_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= '0;
      rr_ptr    <= '0;
    end else if (clear) begin
      ent_valid <= '0;
    end else if (fill_en) begin
      ent_valid[victim] <= 1'b1;
      if (!free_found) begin
        rr_ptr <= (rr_ptr == IDX_W'(DEPTH - 1)) ? '0 : rr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !clear) begin
      ent_vpn[victim]   <= fill_vpn;
      ent_frame[victim] <= fill_frame;
    end
  end

  // R7: a page never sits in two slots
  p_one_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));

  // R6: after a clear nothing can hit
  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !lk_hit);

endmodule

// File: rtl/xlat_sat_ctr.sv
module xlat_sat_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (inc && (count != {W{1'b1}})) begin
      count <= count + 1'b1;
    end
  end

  p_sat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == {W{1'b1}}) |=> (count == {W{1'b1}}));

  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && (count != {W{1'b1}})) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int unsigned LADDR_W   = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned FRAME_W   = 20,
  parameter int unsigned MEM_AW    = 32,
  parameter int unsigned PTE_W     = 32,
  localparam int unsigned VPN_W    = LADDR_W - PAGE_BITS,
  localparam int unsigned LEN_W    = VPN_W + 1,
  localparam int unsigned PADDR_W  = FRAME_W + PAGE_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MEM_AW-1:0]  tbl_base,
  input  logic [LEN_W-1:0]   tbl_len,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LADDR_W-1:0] req_laddr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PADDR_W-1:0] rsp_paddr,
  output logic               rsp_fault,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [MEM_AW-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  output logic [VPN_W-1:0]   lk_vpn,
  input  logic               lk_hit,
  input  logic [FRAME_W-1:0] lk_frame,
  output logic               fill_en,
  output logic [VPN_W-1:0]   fill_vpn,
  output logic [FRAME_W-1:0] fill_frame,
  output logic               hit_inc,
  output logic               miss_inc
);

  walk_state_e          state;
  logic [VPN_W-1:0]     vpn_q;
  logic [PAGE_BITS-1:0] off_q;
  logic [FRAME_W-1:0]   frame_q;
  logic [MEM_AW-1:0]    addr_q;
  logic [VPN_W-1:0]     vpn_in;
  logic [PAGE_BITS-1:0] off_in;
  logic                 rsp_free;
  logic                 accept;
  logic                 in_range;
  logic                 pte_valid;
  logic [FRAME_W-1:0]   pte_frame;
  logic                 unused_pte;

  assign vpn_in    = req_laddr[LADDR_W-1:PAGE_BITS];
  assign off_in    = req_laddr[PAGE_BITS-1:0];
  assign rsp_free  = !rsp_valid || rsp_ready;
  assign req_ready = (state == S_IDLE) && rsp_free;
  assign accept    = req_valid && req_ready;
  assign in_range  = {1'b0, vpn_in} < tbl_len;
  assign lk_vpn    = vpn_in;

  assign pte_valid  = mem_rsp_data[PTE_W-1];
  assign pte_frame  = mem_rsp_data[FRAME_W-1:0];
  assign unused_pte = ^mem_rsp_data[PTE_W-2:FRAME_W];

  assign mem_req_valid = (state == S_FETCH);
  assign mem_req_addr  = addr_q;

  assign fill_en    = (state == S_WAIT) && mem_rsp_valid && pte_valid;
  assign fill_vpn   = vpn_q;
  assign fill_frame = pte_frame;

  assign hit_inc  = accept && in_range && lk_hit;
  assign miss_inc = accept && in_range && !lk_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
      vpn_q     <= '0;
      off_q     <= '0;
      frame_q   <= '0;
      addr_q    <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            vpn_q <= vpn_in;
            off_q <= off_in;
            if (!in_range) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_paddr <= '0;
            end else if (lk_hit) begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b0;
              rsp_paddr <= {lk_frame, off_in};
            end else begin
              addr_q <= tbl_base + (MEM_AW'(vpn_in) << PTE_SHIFT);
              state  <= S_FETCH;
            end
          end
        end
        S_FETCH: begin
          if (mem_req_ready) state <= S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            if (pte_valid) begin
              frame_q <= pte_frame;
              state   <= S_FILL;
            end else begin
              rsp_valid <= 1'b1;
              rsp_fault <= 1'b1;
              rsp_paddr <= '0;
              state     <= S_IDLE;
            end
          end
        end
        S_FILL: begin
          if (rsp_free) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_paddr <= {frame_q, off_q};
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_len_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_range) |=> (rsp_valid && rsp_fault && !mem_req_valid));

  p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_walk_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (!req_ready && !rsp_valid));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  p_fill_reply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> !rsp_valid ##1 (rsp_valid && !rsp_fault));

endmodule

// File: rtl/xlat_paging_mmu.sv
module xlat_paging_mmu
  import xlat_pkg::*;
#(
  parameter int unsigned LADDR_W   = 32,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned FRAME_W   = 20,
  parameter int unsigned MEM_AW    = 32,
  parameter int unsigned PTE_W     = 32,
  parameter int unsigned TLB_DEPTH = 8,
  parameter int unsigned CNT_W     = 16,
  localparam int unsigned VPN_W    = LADDR_W - PAGE_BITS,
  localparam int unsigned LEN_W    = VPN_W + 1,
  localparam int unsigned PADDR_W  = FRAME_W + PAGE_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               cfg_we,
  input  logic               cfg_sel,
  input  logic [MEM_AW-1:0]  cfg_wdata,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [LADDR_W-1:0] req_laddr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PADDR_W-1:0] rsp_paddr,
  output logic               rsp_fault,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [MEM_AW-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  output logic [CNT_W-1:0]   hit_count,
  output logic [CNT_W-1:0]   miss_count
);

  if ((PAGE_BITS < MIN_PAGE_BITS) || (PAGE_BITS > MAX_PAGE_BITS)) begin : g_bad_page
    $error("PAGE_BITS must give a page of 512 to 8192 bytes");
  end

  logic [MEM_AW-1:0]  tbl_base;
  logic [LEN_W-1:0]   tbl_len;
  logic               clear_all;
  logic [VPN_W-1:0]   lk_vpn;
  logic               lk_hit;
  logic [FRAME_W-1:0] lk_frame;
  logic               fill_en;
  logic [VPN_W-1:0]   fill_vpn;
  logic [FRAME_W-1:0] fill_frame;
  logic [1:0]         ctr_inc;
  logic [CNT_W-1:0]   ctr_val [2];
  logic               unused_cfg;

  assign unused_cfg = ^cfg_wdata[MEM_AW-1:LEN_W];
  assign clear_all  = flush || (cfg_we && (cfg_sel == CFG_BASE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_base <= '0;
      tbl_len  <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == CFG_BASE) tbl_base <= cfg_wdata;
      else                     tbl_len  <= cfg_wdata[LEN_W-1:0];
    end
  end

  xlat_walker #(
    .LADDR_W   (LADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .FRAME_W   (FRAME_W),
    .MEM_AW    (MEM_AW),
    .PTE_W     (PTE_W)
  ) u_walker (
    .clk           (clk),
    .rst_n         (rst_n),
    .tbl_base      (tbl_base),
    .tbl_len       (tbl_len),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_laddr     (req_laddr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .lk_vpn        (lk_vpn),
    .lk_hit        (lk_hit),
    .lk_frame      (lk_frame),
    .fill_en       (fill_en),
    .fill_vpn      (fill_vpn),
    .fill_frame    (fill_frame),
    .hit_inc       (ctr_inc[0]),
    .miss_inc      (ctr_inc[1])
  );

  xlat_tlb #(
    .DEPTH   (TLB_DEPTH),
    .VPN_W   (VPN_W),
    .FRAME_W (FRAME_W)
  ) u_tlb (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear_all),
    .lk_vpn     (lk_vpn),
    .lk_hit     (lk_hit),
    .lk_frame   (lk_frame),
    .fill_en    (fill_en),
    .fill_vpn   (fill_vpn),
    .fill_frame (fill_frame)
  );

  for (genvar c = 0; c < 2; c++) begin : g_ctr
    xlat_sat_ctr #(.W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (ctr_inc[c]),
      .count (ctr_val[c])
    );
  end

  assign hit_count  = ctr_val[0];
  assign miss_count = ctr_val[1];

  // R6: a base write leaves nothing to hit
  p_base_write_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_sel == CFG_BASE)) |=> !lk_hit);

endmodule

// File: tb/xlat_paging_mmu_bench.sv
`timescale 1ns/1ps
module xlat_paging_mmu_bench;

  localparam int DEPTH = 8;
  localparam int PB    = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic [15:0] hit_count;
  logic [15:0] miss_count;

  always #2.5 clk = ~clk;

  xlat_paging_mmu u_xlat_paging_mmu (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  int checks = 0;
  int fails  = 0;
  bit mon_on = 1'b0;

  // behavioural model
  bit mv   [DEPTH];
  int mvpn [DEPTH];
  int mfr  [DEPTH];
  int mrr   = 0;
  int mbase = 0;
  int mlen  = 0;
  int mhits = 0;
  int mmiss = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pte_of(input int vpn);
    logic [31:0] d;
    d = 32'((20'h80000 + vpn * 17) & 20'hFFFFF);
    d[31] = !(vpn == 5 || vpn == 40);
    return d;
  endfunction

  function automatic bit mlook(input int vpn, output int fr);
    fr = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (mv[i] && mvpn[i] == vpn) begin
        fr = mfr[i];
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  function automatic void mfill(input int vpn, input int fr);
    int slot;
    slot = -1;
    for (int i = DEPTH - 1; i >= 0; i--) if (!mv[i]) slot = i;
    if (slot < 0) begin
      slot = mrr;
      mrr  = (mrr + 1) % DEPTH;
    end
    mv[slot]   = 1'b1;
    mvpn[slot] = vpn;
    mfr[slot]  = fr;
  endfunction

  function automatic void mflush();
    for (int i = 0; i < DEPTH; i++) mv[i] = 1'b0;
  endfunction

  // counters compared every clock (R10)
  always @(negedge clk) begin
    if (mon_on) begin
      chk(hit_count == 16'(mhits), "R10", "hit_count", hit_count, mhits);
      chk(miss_count == 16'(mmiss), "R10", "miss_count", miss_count, mmiss);
    end
  end

  task automatic cfg_write(input bit sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = 32'(val);
    @(posedge clk);
    if (sel) mlen = val; else begin mbase = val; mflush(); end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk);
    mflush();
    @(negedge clk);
    flush = 1'b0;
  endtask

  // kind: 0 hit, 1 length fault, 2 miss
  task automatic xlat(input int vpn, input int off, input int stall,
                      input int lat, input int hold, input string tag,
                      input int want_kind);
    int  fr;
    int  kind;
    bit  hit;
    logic [31:0] pte;
    logic [31:0] exp_pa;
    bit  exp_fault;
    @(negedge clk);
    rsp_ready = (hold == 0);
    req_valid = 1'b1;
    req_laddr = 32'((vpn << PB) | off);
    chk(req_ready == 1'b1, "R8", "req_ready idle", req_ready, 1);
    hit = mlook(vpn, fr);
    if (vpn >= mlen) kind = 1; else if (hit) kind = 0; else kind = 2;
    if (want_kind >= 0) chk(kind == want_kind, tag, "model kind", kind, want_kind);
    @(posedge clk);
    if (kind == 0) mhits = (mhits < 65535) ? mhits + 1 : 65535;
    if (kind == 2) mmiss = (mmiss < 65535) ? mmiss + 1 : 65535;
    @(negedge clk);
    req_valid = 1'b0;
    exp_fault = 1'b0;
    exp_pa = '0;
    if (kind == 2) begin
      chk(rsp_valid == 1'b0, tag, "no rsp during walk", rsp_valid, 0);
      chk(mem_req_valid == 1'b1, "R2", "mem_req_valid", mem_req_valid, 1);
      chk(mem_req_addr == 32'(mbase + vpn * 4), "R2", "mem_req_addr",
          mem_req_addr, mbase + vpn * 4);
      chk(req_ready == 1'b0, "R8", "req_ready in walk", req_ready, 0);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(mem_req_valid == 1'b1 && mem_req_addr == 32'(mbase + vpn * 4),
            "R2", "mem_req held", mem_req_addr, mbase + vpn * 4);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(mem_req_valid == 1'b0, "R2", "mem_req dropped", mem_req_valid, 0);
      for (int s = 0; s < lat; s++) begin
        @(negedge clk);
        chk(req_ready == 1'b0 && rsp_valid == 1'b0, "R8", "blocked in wait",
            req_ready, 0);
      end
      pte = pte_of(vpn);
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = pte;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pte[31]) begin
        chk(rsp_valid == 1'b0 && req_ready == 1'b0, "R3", "fill cycle", rsp_valid, 0);
        mfill(vpn, int'(pte[19:0]));
        @(negedge clk);
        exp_pa = {pte[19:0], 12'(off)};
      end else begin
        exp_fault = 1'b1;
      end
    end else if (kind == 1) begin
      exp_fault = 1'b1;
      chk(mem_req_valid == 1'b0, "R4", "no read on length fault", mem_req_valid, 0);
    end else begin
      exp_pa = {20'(fr), 12'(off)};
      chk(mem_req_valid == 1'b0, "R1", "no read on hit", mem_req_valid, 0);
    end
    chk(rsp_valid == 1'b1, tag, "rsp_valid", rsp_valid, 1);
    chk(rsp_fault == exp_fault, tag, "rsp_fault", rsp_fault, exp_fault);
    chk(rsp_paddr == exp_pa, tag, "rsp_paddr", rsp_paddr, exp_pa);
    if (hold > 0) begin
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(rsp_valid == 1'b1 && rsp_paddr == exp_pa && rsp_fault == exp_fault,
            "R9", "held rsp", rsp_paddr, exp_pa);
        chk(req_ready == 1'b0, "R8", "ready low while held", req_ready, 0);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R9", "rsp taken", rsp_valid, 0);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mv[i] = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 / R10 reset state
    chk(req_ready == 1'b1, "R8", "reset req_ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R8", "reset rsp_valid", rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R8", "reset mem_req_valid", mem_req_valid, 0);
    chk(hit_count == 0 && miss_count == 0, "R10", "reset counters", hit_count, 0);
    mon_on = 1'b1;

    // R4: table length 0 after reset
    xlat(2, 16'h10, 0, 0, 0, "R4", 1);

    cfg_write(1'b1, 64);
    cfg_write(1'b0, 32'h0010_0000);

    xlat(3, 12'hABC, 2, 3, 0, "R3", 2);   // miss, refill
    xlat(3, 12'h123, 0, 0, 0, "R1", 0);   // hit
    xlat(5, 12'h001, 0, 1, 0, "R5", 2);   // invalid entry
    xlat(5, 12'h002, 1, 0, 0, "R5", 2);   // misses again
    xlat(64, 12'h0, 0, 0, 0, "R4", 1);    // boundary: equal to length
    xlat(63, 12'hFFF, 0, 0, 0, "R2", 2);  // last legal page
    xlat(63, 12'h000, 0, 0, 0, "R1", 0);

    // fill the rest, then force round-robin eviction
    for (int p = 10; p < 16; p++) xlat(p, p, 0, 0, 0, "R7", 2);
    xlat(20, 12'h44, 0, 2, 0, "R7", 2);   // evicts slot 0 (page 3)
    xlat(3, 12'h55, 0, 0, 0, "R7", 2);    // page 3 gone; evicts slot 1
    xlat(63, 12'h66, 0, 0, 0, "R7", 2);   // page 63 gone
    xlat(12, 12'h77, 0, 0, 0, "R7", 0);   // untouched slot still hits

    // response held by the consumer
    xlat(12, 12'h88, 0, 0, 3, "R9", 0);
    xlat(99, 12'h0, 0, 0, 2, "R9", 1);

    // length write does not flush, base write and flush pulse do
    cfg_write(1'b1, 100);
    xlat(12, 12'h99, 0, 0, 0, "R6", 0);
    pulse_flush();
    xlat(12, 12'h9A, 0, 0, 0, "R6", 2);
    xlat(12, 12'h9B, 0, 0, 0, "R6", 0);
    cfg_write(1'b0, 32'h0010_0000);
    xlat(12, 12'h9C, 0, 0, 0, "R6", 2);

    // R10 saturation with back-to-back hits
    @(negedge clk);
    rsp_ready = 1'b1;
    req_valid = 1'b1;
    req_laddr = 32'((12 << PB) | 12'h1);
    repeat (65540) begin
      @(posedge clk);
      mhits = (mhits < 65535) ? mhits + 1 : 65535;
    end
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(hit_count == 16'hFFFF, "R10", "hit saturation", hit_count, 16'hFFFF);
    xlat(12, 12'h2, 0, 0, 0, "R10", 0);
    chk(hit_count == 16'hFFFF, "R10", "hit stays saturated", hit_count, 16'hFFFF);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule